// File: doc/BRIEF.md
# Multi-Mode Conversion Result Readout Port

This block is the host-facing output stage of an eight-channel converter. It holds the most recently published set of channel results. When chip select falls, it freezes that set in a snapshot and then shows the snapshot to the host in one of three modes:

- **Parallel:** one full 16-bit word per read strobe.
- **Byte:** two 8-bit halves per channel, in a selectable order.
- **Serial:** two lines, clocked by the same strobe pin. The lines walk the two channel halves in opposite orders.

Each channel word is the 14-bit result with two zero bits appended below it. A first-channel flag tells the host when channel 1 is on the outputs. It follows a different edge rule in each mode.

New results come in with a one-cycle commit strobe, normally on the falling edge of the converter's busy signal. A read frame that is open when a commit arrives must not see its data change part way through. So a commit that lands while chip select is low is held until chip select rises, and a sticky overrun flag records that this happened.

All pins are sampled on `clk`. A strobe edge takes effect on the outputs one clock after it is sampled. Output enables stand in for tri-state control. When an enable is low, the data it guards is driven to zero.

Top module: `adc_readout_port`

## Requirements
- R1: The mode comes from two pins. `par_ser`=0 selects parallel whatever `byte_sel` is, and drives `db_oe`=2'b11 (all 16 lanes) when enabled. `par_ser`=1 with `byte_sel`=1 selects byte mode, and drives `db_oe`=2'b01 (lanes 7:0 only). `par_ser`=1 with `byte_sel`=0 selects serial: `db_oe` stays 2'b00 and `dout_oe` is high while `cs_n` is low.
- R2: In parallel and byte modes, `db_oe` is nonzero only while `cs_n` and `rd_sclk` are both low and at least one read falling edge has been taken in the frame. Otherwise `db_oe`=0 and `db`=0.
- R3: `frst_oe` is high exactly while `cs_n` is low and the block is out of reset. While `cs_n` is high, `frst` and `frst_oe` are 0 and all read counters are cleared, so the next frame starts again at channel 1.
- R4: The word for channel k is {result_k[13:0], 2'b00}. Channel k (k = 0..7, where 0 is channel 1) occupies bits k*14 +: 14 of `res_in`.
- R5: In parallel mode, the first read falling edge of a frame presents channel 1 and each later one moves to the next higher channel, wrapping after channel 8. `frst` is 1 after the first falling edge and 0 from the second onward.
- R6: In byte mode each channel takes two reads, 16 in all. With `hi_first`=1 the first read of a channel gives word bits 15:8 and the second gives bits 7:0; with `hi_first`=0 the order is reversed. `frst` is 1 after the first and second reads and 0 from the third onward.
- R7: In serial mode, the MSB of the first word is on the lines once `cs_n` falls. Each rising `rd_sclk` edge moves one bit lower, with 14 bits per channel, MSB first. `dout_a` carries channels 1..8 in that order. `dout_b` carries channels 5..8 and then 1..4, so 56 clocks deliver all channels on both lines and 112 clocks deliver all eight on one line.
- R8: In serial mode, `frst` is 1 from the fall of `cs_n` until the 14th falling `rd_sclk` edge, and 0 after it.
- R9: A commit while `cs_n` is high publishes `res_in` at that clock edge. A commit while `cs_n` is low is held and published once `cs_n` is high, and it sets `overrun`, which stays 1 until reset. A frame always reads the set that was published when its `cs_n` fell.
- R10: Reset (synchronous, active high) zeroes the published results and `overrun`, and forces every output enable to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all pins sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select framing a read |
| rd_sclk | input | 1 | Active-low read strobe (parallel and byte modes) or serial clock |
| par_ser | input | 1 | 0 selects parallel, 1 selects byte or serial |
| byte_sel | input | 1 | With `par_ser`=1: 1 selects byte mode, 0 selects serial |
| hi_first | input | 1 | Byte mode order: 1 gives the high byte first |
| commit | input | 1 | One-cycle strobe publishing `res_in` |
| res_in | input | 112 | Eight 14-bit results, channel k at bits k*14 +: 14 |
| db | output | 16 | Parallel data bus; lanes 7:0 only in byte mode |
| db_oe | output | 2 | Bus enables: bit 1 for lanes 15:8, bit 0 for lanes 7:0 |
| dout_a | output | 1 | Serial line A |
| dout_b | output | 1 | Serial line B |
| dout_oe | output | 1 | Enable for both serial lines |
| frst | output | 1 | First-channel flag |
| frst_oe | output | 1 | Enable for the first-channel flag |
| overrun | output | 1 | Sticky: a commit arrived during an open frame |

## Verification
A result commit and the opening of a read frame can fall in the same clock. The snapshot must take the previously published set, while the new set waits until the frame closes. The bench provokes this by dropping `cs_n` in the very cycle that carries a commit. It then checks three things: the frame still reads the older values, `overrun` is set, and the following frame reads the committed values. A separate commit made while `cs_n` is high checks the direct path and shows that it leaves `overrun` clear.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    localparam int DEF_NCH   = 8;
    localparam int DEF_RES_W = 14;
    localparam int PAD_W     = 2;

    typedef enum logic [1:0] {
        RM_PAR  = 2'd0,
        RM_BYTE = 2'd1,
        RM_SER  = 2'd2
    } rmode_e;

    function automatic rmode_e decode_mode(input logic par_ser, input logic byte_sel);
        if (!par_ser)
            return RM_PAR;
        else if (byte_sel)
            return RM_BYTE;
        else
            return RM_SER;
    endfunction

endpackage

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
    import adc_rd_pkg::*;
#(
    parameter int NCH   = DEF_NCH,
    parameter int RES_W = DEF_RES_W,
    localparam int CH_W  = $clog2(NCH),
    localparam int POS_W = CH_W + 1,
    localparam int BIT_W = $clog2(RES_W),
    localparam int SF_W  = $clog2(RES_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             rd_sclk,
    output logic             cs_fall,
    output logic             started,
    output logic [POS_W-1:0] pos,
    output logic [BIT_W-1:0] bit_idx,
    output logic [CH_W-1:0]  ser_ch,
    output logic [SF_W-1:0]  sfall
);

    logic cs_q;
    logic rd_q;
    logic rd_fall;
    logic rd_rise;

    assign cs_fall = cs_q && !cs_n;
    assign rd_fall = rd_q && !rd_sclk;
    assign rd_rise = !rd_q && rd_sclk;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q    <= 1'b1;
            rd_q    <= 1'b1;
            started <= 1'b0;
            pos     <= '0;
            bit_idx <= '0;
            ser_ch  <= '0;
            sfall   <= '0;
        end else begin
            cs_q <= cs_n;
            rd_q <= rd_sclk;
            if (cs_n) begin
                started <= 1'b0;
                pos     <= '0;
                bit_idx <= '0;
                ser_ch  <= '0;
                sfall   <= '0;
            end else begin
                // parallel / byte read index
                if (rd_fall) begin
                    if (!started)
                        started <= 1'b1;
                    else
                        pos <= pos + 1'b1;
                    if (sfall != SF_W'(RES_W))
                        sfall <= sfall + 1'b1;
                end
                // serial bit walk
                if (rd_rise) begin
                    if (bit_idx == BIT_W'(RES_W - 1)) begin
                        bit_idx <= '0;
                        ser_ch  <= ser_ch + 1'b1;
                    end else begin
                        bit_idx <= bit_idx + 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/adc_rd_bank.sv
module adc_rd_bank
    import adc_rd_pkg::*;
#(
    parameter int NCH   = DEF_NCH,
    parameter int RES_W = DEF_RES_W,
    localparam int SET_W = NCH * RES_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             cs_fall,
    input  logic             commit,
    input  logic [SET_W-1:0] res_in,
    output logic [SET_W-1:0] snap,
    output logic             overrun
);

    logic [SET_W-1:0] pub_q;
    logic [SET_W-1:0] pend_q;
    logic             pend_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            pub_q    <= '0;
            pend_q   <= '0;
            pend_vld <= 1'b0;
            snap     <= '0;
            overrun  <= 1'b0;
        end else begin
            if (commit && cs_n) begin
                pub_q    <= res_in;
                pend_vld <= 1'b0;
            end else if (commit) begin
                pend_q   <= res_in;
                pend_vld <= 1'b1;
                overrun  <= 1'b1;
            end else if (pend_vld && cs_n) begin
                pub_q    <= pend_q;
                pend_vld <= 1'b0;
            end
            if (cs_fall)
                snap <= pub_q;
        end
    end

endmodule

// File: rtl/adc_rd_outmux.sv
module adc_rd_outmux
    import adc_rd_pkg::*;
#(
    parameter int NCH   = DEF_NCH,
    parameter int RES_W = DEF_RES_W,
    localparam int SET_W  = NCH * RES_W,
    localparam int WORD_W = RES_W + PAD_W,
    localparam int BYTE_W = WORD_W / 2,
    localparam int CH_W   = $clog2(NCH),
    localparam int POS_W  = CH_W + 1,
    localparam int BIT_W  = $clog2(RES_W),
    localparam int SF_W   = $clog2(RES_W + 1)
) (
    input  logic              rst,
    input  logic              cs_n,
    input  logic              rd_sclk,
    input  rmode_e            mode,
    input  logic              hi_first,
    input  logic [SET_W-1:0]  snap,
    input  logic              started,
    input  logic [POS_W-1:0]  pos,
    input  logic [BIT_W-1:0]  bit_idx,
    input  logic [CH_W-1:0]   ser_ch,
    input  logic [SF_W-1:0]   sfall,
    output logic [WORD_W-1:0] db,
    output logic [1:0]        db_oe,
    output logic              dout_a,
    output logic              dout_b,
    output logic              dout_oe,
    output logic              frst,
    output logic              frst_oe
);

    logic [RES_W-1:0]  ch_res [NCH];
    logic [WORD_W-1:0] words  [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_unpack
        assign ch_res[g] = snap[g*RES_W +: RES_W];
        assign words[g]  = {ch_res[g], {PAD_W{1'b0}}};
    end

    logic              live;
    logic              read_ok;
    logic              sel_hi;
    logic              flag_val;
    logic [WORD_W-1:0] byte_word;
    logic [BYTE_W-1:0] byte_val;
    logic [CH_W-1:0]   ch_b;
    logic [BIT_W-1:0]  bit_pos;

    always_comb begin
        live      = !rst && !cs_n;
        read_ok   = live && !rd_sclk && started;
        byte_word = words[pos[CH_W:1]];
        sel_hi    = hi_first ^ pos[0];
        byte_val  = sel_hi ? byte_word[WORD_W-1 -: BYTE_W] : byte_word[BYTE_W-1:0];
        ch_b      = ser_ch + CH_W'(NCH / 2);
        bit_pos   = BIT_W'(RES_W - 1) - bit_idx;

        db       = '0;
        db_oe    = 2'b00;
        dout_a   = 1'b0;
        dout_b   = 1'b0;
        dout_oe  = 1'b0;
        flag_val = 1'b0;

        unique case (mode)
            RM_PAR: begin
                flag_val = started && (pos == '0);
                if (read_ok) begin
                    db    = words[pos[CH_W-1:0]];
                    db_oe = 2'b11;
                end
            end
            RM_BYTE: begin
                flag_val = started && (pos[CH_W:1] == '0);
                if (read_ok) begin
                    db    = {{(WORD_W-BYTE_W){1'b0}}, byte_val};
                    db_oe = 2'b01;
                end
            end
            default: begin
                flag_val = sfall < SF_W'(RES_W);
                dout_oe  = live;
                if (live) begin
                    dout_a = ch_res[ser_ch][bit_pos];
                    dout_b = ch_res[ch_b][bit_pos];
                end
            end
        endcase

        frst_oe = live;
        frst    = live && flag_val;
    end

endmodule

// File: rtl/adc_readout_port.sv
module adc_readout_port
    import adc_rd_pkg::*;
#(
    parameter int NCH   = DEF_NCH,
    parameter int RES_W = DEF_RES_W,
    localparam int SET_W  = NCH * RES_W,
    localparam int WORD_W = RES_W + PAD_W,
    localparam int CH_W   = $clog2(NCH),
    localparam int POS_W  = CH_W + 1,
    localparam int BIT_W  = $clog2(RES_W),
    localparam int SF_W   = $clog2(RES_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              rd_sclk,
    input  logic              par_ser,
    input  logic              byte_sel,
    input  logic              hi_first,
    input  logic              commit,
    input  logic [SET_W-1:0]  res_in,
    output logic [WORD_W-1:0] db,
    output logic [1:0]        db_oe,
    output logic              dout_a,
    output logic              dout_b,
    output logic              dout_oe,
    output logic              frst,
    output logic              frst_oe,
    output logic              overrun
);

    rmode_e           mode;
    logic             cs_fall;
    logic             started;
    logic [POS_W-1:0] pos;
    logic [BIT_W-1:0] bit_idx;
    logic [CH_W-1:0]  ser_ch;
    logic [SF_W-1:0]  sfall;
    logic [SET_W-1:0] snap;

    assign mode = decode_mode(par_ser, byte_sel);

    adc_rd_seq #(.NCH(NCH), .RES_W(RES_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .cs_n    (cs_n),
        .rd_sclk (rd_sclk),
        .cs_fall (cs_fall),
        .started (started),
        .pos     (pos),
        .bit_idx (bit_idx),
        .ser_ch  (ser_ch),
        .sfall   (sfall)
    );

    adc_rd_bank #(.NCH(NCH), .RES_W(RES_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .cs_n    (cs_n),
        .cs_fall (cs_fall),
        .commit  (commit),
        .res_in  (res_in),
        .snap    (snap),
        .overrun (overrun)
    );

    adc_rd_outmux #(.NCH(NCH), .RES_W(RES_W)) u_mux (
        .rst      (rst),
        .cs_n     (cs_n),
        .rd_sclk  (rd_sclk),
        .mode     (mode),
        .hi_first (hi_first),
        .snap     (snap),
        .started  (started),
        .pos      (pos),
        .bit_idx  (bit_idx),
        .ser_ch   (ser_ch),
        .sfall    (sfall),
        .db       (db),
        .db_oe    (db_oe),
        .dout_a   (dout_a),
        .dout_b   (dout_b),
        .dout_oe  (dout_oe),
        .frst     (frst),
        .frst_oe  (frst_oe)
    );

endmodule

// File: rtl/adc_readout_port_chk.sv
module adc_readout_port_chk
    import adc_rd_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       rd_sclk,
    input logic       par_ser,
    input logic       byte_sel,
    input logic       commit,
    input logic [1:0] db_oe,
    input logic       dout_oe,
    input logic       frst,
    input logic       frst_oe,
    input logic       overrun
);

    a_r2_bus_needs_strobes: assert property (@(posedge clk) disable iff (rst)
        (db_oe != 2'b00) |-> (!cs_n && !rd_sclk));

    a_r1_serial_bus_quiet: assert property (@(posedge clk) disable iff (rst)
        (decode_mode(par_ser, byte_sel) == RM_SER) |-> (db_oe == 2'b00));

    a_r1_serial_lines_gated: assert property (@(posedge clk) disable iff (rst)
        dout_oe |-> (!cs_n && decode_mode(par_ser, byte_sel) == RM_SER));

    a_r6_byte_low_lanes: assert property (@(posedge clk) disable iff (rst)
        (decode_mode(par_ser, byte_sel) == RM_BYTE) |-> !db_oe[1]);

    a_r3_flag_released: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (!frst_oe && !frst));

    a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

    a_r9_overrun_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> $past(commit && !cs_n));

endmodule

bind adc_readout_port adc_readout_port_chk u_chk (.*);

// File: tb/adc_readout_port_test.sv
module adc_readout_port_test;

    localparam int CLK_P  = 10;
    localparam int NCH    = 8;
    localparam int RES_W  = 14;
    localparam int WD_CYC = 20000;

    logic              clk = 1'b0;
    logic              rst;
    logic              cs_n;
    logic              rd_sclk;
    logic              par_ser;
    logic              byte_sel;
    logic              hi_first;
    logic              commit;
    logic [NCH*RES_W-1:0] res_in;
    logic [15:0]       db;
    logic [1:0]        db_oe;
    logic              dout_a;
    logic              dout_b;
    logic              dout_oe;
    logic              frst;
    logic              frst_oe;
    logic              overrun;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    adc_readout_port uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_sclk(rd_sclk),
        .par_ser(par_ser), .byte_sel(byte_sel), .hi_first(hi_first),
        .commit(commit), .res_in(res_in), .db(db), .db_oe(db_oe),
        .dout_a(dout_a), .dout_b(dout_b), .dout_oe(dout_oe),
        .frst(frst), .frst_oe(frst_oe), .overrun(overrun)
    );

    typedef struct packed {
        logic        ps;
        logic        bs;
        logic        hf;
        logic [4:0]  nrd;
        logic [15:0] exp_db;
        logic [1:0]  exp_oe;
        logic        exp_f;
    } vec_t;

    // results of set 0: channel k holds ((k+1)<<9)|(k+1); word = result<<2
    localparam vec_t VECS [10] = '{
        '{1'b0, 1'b0, 1'b0, 5'd1,  16'h0804, 2'b11, 1'b1},
        '{1'b0, 1'b0, 1'b0, 5'd2,  16'h1008, 2'b11, 1'b0},
        '{1'b0, 1'b0, 1'b0, 5'd8,  16'h4020, 2'b11, 1'b0},
        '{1'b1, 1'b1, 1'b1, 5'd1,  16'h0008, 2'b01, 1'b1},
        '{1'b1, 1'b1, 1'b1, 5'd2,  16'h0004, 2'b01, 1'b1},
        '{1'b1, 1'b1, 1'b1, 5'd3,  16'h0010, 2'b01, 1'b0},
        '{1'b1, 1'b1, 1'b0, 5'd1,  16'h0004, 2'b01, 1'b1},
        '{1'b1, 1'b1, 1'b0, 5'd4,  16'h0010, 2'b01, 1'b0},
        '{1'b1, 1'b1, 1'b0, 5'd16, 16'h0040, 2'b01, 1'b0},
        '{1'b0, 1'b1, 1'b0, 5'd3,  16'h180C, 2'b11, 1'b0}
    };

    function automatic logic [RES_W-1:0] res_val(input int set, input int k);
        logic [RES_W-1:0] base;
        base = RES_W'(((k + 1) << 9) | (k + 1));
        if (set == 1) return ~base;
        if (set == 2) return base ^ 14'h1555;
        return base;
    endfunction

    task automatic load_set(input int set);
        for (int k = 0; k < NCH; k++) res_in[k*RES_W +: RES_W] = res_val(set, k);
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_commit(input int set);
        load_set(set);
        commit = 1'b1;
        step();
        commit = 1'b0;
    endtask

    task automatic par_first_word(output logic [15:0] w);
        par_ser = 1'b0; byte_sel = 1'b0; rd_sclk = 1'b1; cs_n = 1'b1; step();
        cs_n = 1'b0; step();
        rd_sclk = 1'b0; step();
        w = db;
    endtask

    task automatic close_frame();
        rd_sclk = 1'b1; cs_n = 1'b1; step();
    endtask

    // gathers one 14-bit word from each serial line, 14 clocks
    task automatic ser_word(output logic [RES_W-1:0] wa, output logic [RES_W-1:0] wb);
        for (int b = RES_W - 1; b >= 0; b--) begin
            wa[b] = dout_a;
            wb[b] = dout_b;
            rd_sclk = 1'b1; step();
            rd_sclk = 1'b0; step();
        end
    endtask

    initial begin
        repeat (WD_CYC) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0]      w;
        logic [RES_W-1:0] wa;
        logic [RES_W-1:0] wb;
        rst = 1'b1; cs_n = 1'b1; rd_sclk = 1'b1; par_ser = 1'b0;
        byte_sel = 1'b0; hi_first = 1'b1; commit = 1'b0; res_in = '0;
        step(); step();
        rst = 1'b0; step();

        // R10 reset state
        check("R10 db_oe after reset", 32'(db_oe), 32'd0);
        check("R10 dout_oe after reset", 32'(dout_oe), 32'd0);
        check("R10 overrun after reset", 32'(overrun), 32'd0);
        par_first_word(w);
        check("R10 published results zero", 32'(w), 32'h0);
        close_frame();

        // R9 commit with cs high publishes directly, no overrun
        do_commit(0);
        check("R9 direct commit leaves overrun clear", 32'(overrun), 32'd0);

        // R2 bus stays off without both strobes
        cs_n = 1'b0; rd_sclk = 1'b1; step(); step();
        check("R2 cs low rd high: db_oe", 32'(db_oe), 32'd0);
        check("R3 flag enable while cs low", 32'(frst_oe), 32'd1);
        check("R3 flag low before first read", 32'(frst), 32'd0);
        close_frame();
        rd_sclk = 1'b0; step();
        check("R2 rd low cs high: db_oe", 32'(db_oe), 32'd0);
        check("R2 rd low cs high: db", 32'(db), 32'd0);
        check("R3 flag enable with cs high", 32'(frst_oe), 32'd0);
        rd_sclk = 1'b1; step();

        // R1 R4 R5 R6 table walk
        foreach (VECS[i]) begin
            string tag;
            tag = VECS[i].ps ? "R6" : "R5";
            par_ser = VECS[i].ps; byte_sel = VECS[i].bs; hi_first = VECS[i].hf;
            cs_n = 1'b1; rd_sclk = 1'b1; step();
            cs_n = 1'b0; step();
            for (int k = 0; k < int'(VECS[i].nrd); k++) begin
                rd_sclk = 1'b0; step();
                if (k < int'(VECS[i].nrd) - 1) begin
                    rd_sclk = 1'b1; step();
                end
            end
            check($sformatf("%s R4 vector %0d db", tag, i), 32'(db), 32'(VECS[i].exp_db));
            check($sformatf("R1 vector %0d db_oe", i), 32'(db_oe), 32'(VECS[i].exp_oe));
            check($sformatf("%s vector %0d frst", tag, i), 32'(frst), 32'(VECS[i].exp_f));
            rd_sclk = 1'b1; step();
            check($sformatf("R2 vector %0d bus off on rd high", i), 32'(db_oe), 32'd0);
            close_frame();
        end

        // R7 R8 serial mode
        par_ser = 1'b1; byte_sel = 1'b0; rd_sclk = 1'b0; cs_n = 1'b1; step(); step();
        cs_n = 1'b0; step();
        check("R1 serial dout_oe", 32'(dout_oe), 32'd1);
        check("R1 serial db_oe", 32'(db_oe), 32'd0);
        check("R8 serial flag at cs fall", 32'(frst), 32'd1);
        check("R7 MSB at cs fall", 32'(dout_a), 32'(res_val(0, 0) >> (RES_W - 1)));
        for (int b = RES_W - 1; b >= 0; b--) begin
            wa[b] = dout_a;
            wb[b] = dout_b;
            rd_sclk = 1'b1; step();
            rd_sclk = 1'b0; step();
            if (b == 1) check("R8 flag after 13 falls", 32'(frst), 32'd1);
        end
        check("R8 flag after 14 falls", 32'(frst), 32'd0);
        check("R7 line A channel 1", 32'(wa), 32'(res_val(0, 0)));
        check("R7 line B channel 5", 32'(wb), 32'(res_val(0, 4)));
        for (int c = 1; c < 2 * NCH; c++) begin
            ser_word(wa, wb);
            if (c == 3) begin
                check("R7 line A channel 4", 32'(wa), 32'(res_val(0, 3)));
                check("R7 line B channel 8", 32'(wb), 32'(res_val(0, 7)));
            end
            if (c == 4) begin
                check("R7 line A channel 5", 32'(wa), 32'(res_val(0, 4)));
                check("R7 line B channel 1", 32'(wb), 32'(res_val(0, 0)));
            end
            if (c == 7) begin
                check("R7 line A channel 8", 32'(wa), 32'(res_val(0, 7)));
                check("R7 line B channel 4", 32'(wb), 32'(res_val(0, 3)));
            end
        end
        cs_n = 1'b1; step();
        check("R3 serial lines released", 32'(dout_oe), 32'd0);
        rd_sclk = 1'b1; step();

        // R3 counters restart per frame
        par_first_word(w);
        check("R3 new frame restarts at channel 1", 32'(w), 32'h0804);
        close_frame();

        // R9 direct commit then overlap of commit and cs fall
        do_commit(1);
        par_first_word(w);
        check("R9 direct commit visible", 32'(w), 32'({res_val(1, 0), 2'b00}));
        close_frame();
        par_ser = 1'b0; byte_sel = 1'b0; rd_sclk = 1'b1;
        load_set(2);
        commit = 1'b1; cs_n = 1'b0; step();
        commit = 1'b0;
        rd_sclk = 1'b0; step();
        check("R9 frame keeps old set", 32'(db), 32'({res_val(1, 0), 2'b00}));
        check("R9 overrun set", 32'(overrun), 32'd1);
        close_frame();
        par_first_word(w);
        check("R9 held commit published", 32'(w), 32'({res_val(2, 0), 2'b00}));
        check("R9 overrun sticky", 32'(overrun), 32'd1);
        close_frame();

        // R10 reset clears overrun
        rst = 1'b1; step(); step();
        rst = 1'b0; step();
        check("R10 overrun cleared", 32'(overrun), 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule